// File: doc/BRIEF.md
# Two-Wire Register Slave with Auto-Incrementing Read Pointer

This block is a serial slave on a two-wire bus that gives a bus master access to a space of sixteen byte locations. The storage is external. The slave writes into it through a one-cycle write port and reads from it through an address output with a data input.

A transaction opens with an identification byte. That byte carries a fixed four-bit pattern, the three strap bits and a direction bit. For a write, the master then sends a location address and exactly one data byte. For a read, the master sends the address, issues a repeated START and sends the identification byte again with the direction bit set. The slave then streams bytes from a pointer that advances after each byte and wraps from the top location back to zero. The stream continues while the master acknowledges each byte.

Some locations are marked persistent by a parameter mask. A write to one of them arms a commit. The commit starts a timed busy window once STOP is seen. While that window runs, the slave refuses every identification byte.

The bus lines are synchronised and oversampled on the system clock. The controller is an enumerated state machine with these states:
- `S_IDLE`: waits for START.
- `S_ID_RX`: shifts in the identification byte. A match goes to `S_ID_ACK`; a mismatch or a busy window goes back to `S_IDLE`.
- `S_ID_ACK`: drives the acknowledge. On SCL falling it goes to `S_TX` for a read or `S_ADDR_RX` for a write.
- `S_ADDR_RX`: shifts in the address byte, then goes to `S_ADDR_ACK`.
- `S_ADDR_ACK`: drives the acknowledge, then goes to `S_DATA_RX`.
- `S_DATA_RX`: shifts in the data byte and pulses the write port, then goes to `S_DATA_ACK`.
- `S_DATA_ACK`: drives the acknowledge, then goes to `S_IDLE`.
- `S_TX`: shifts a byte out. After the eighth bit it goes to `S_TX_ACK`.
- `S_TX_ACK`: releases SDA and samples the master's acknowledge. It returns to `S_TX` on an acknowledge and to `S_IDLE` on a not-acknowledge.

START moves any state to `S_ID_RX`, and STOP moves any state to `S_IDLE`.

Top module: `i2cr_slave`

## Requirements
- R1: The identification byte is, MSB first, the pattern 1010, then the strap bits A2 A1 A0 (matching `strap_i[2:0]`), then the read/write bit in bit 0 (0 = write, 1 = read). A matching byte is acknowledged (SDA driven low in the ninth clock). A byte that does not match is not acknowledged, and the slave ignores the bus until the next START.
- R2: START is SDA falling while SCL is high, and STOP is SDA rising while SCL is high. STOP returns the slave to idle. A START in any state, including a repeated START in the middle of a transaction, restarts identification-byte reception; a write abandoned this way performs no write.
- R3: In a write, the identification byte, the address byte and the data byte are each acknowledged. When the data byte is acknowledged, `wr_en_o` is high for exactly one system clock, with `wr_addr_o` set to the selected location and `wr_data_o` set to the data byte.
- R4: Only the low four bits of the address byte select a location; the upper four bits are ignored.
- R5: A write transaction stores one data byte only. Any further byte before STOP is not acknowledged and is not written.
- R6: In a read (identification byte with R/W=0, address byte, repeated START, identification byte with R/W=1), the slave acknowledges all three bytes. It then sends data MSB first, starting at the addressed location, and the pointer advances by one after each byte.
- R7: After location 0Fh the read pointer wraps to 00h and streaming continues.
- R8: The slave keeps sending bytes while the master acknowledges. After a not-acknowledge it leaves SDA released until the next START.
- R9: The slave changes SDA only while SCL is low, and it releases SDA during the master's acknowledge bit.
- R10: An acknowledged write to a location whose bit is set in `PERSIST_MASK` raises `busy_o` once STOP is detected, not before. `busy_o` then stays high for exactly `BUSY_CYCLES` system clocks. A write to any other location leaves `busy_o` low.
- R11: While `busy_o` is high, every identification byte is refused with no acknowledge.
- R12: After reset, SDA is released, `busy_o` is low, `wr_en_o` is low and the slave is idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock used to oversample the bus |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen on the wire |
| sda_i | input | 1 | Bus data line as seen on the wire |
| sda_oe_o | output | 1 | High pulls the data line low (open-drain) |
| strap_i | input | 3 | Address strap bits compared with the identification byte |
| wr_en_o | output | 1 | One-cycle write strobe to the register file |
| wr_addr_o | output | ADDR_W | Location being written |
| wr_data_o | output | 8 | Byte being written |
| rd_addr_o | output | ADDR_W | Location the slave is reading (the pointer) |
| rd_data_i | input | 8 | Byte stored at `rd_addr_o` |
| busy_o | output | 1 | Persistent commit window in progress |

## Verification
The bench builds the slave with `BUSY_CYCLES` = 400, which makes the full busy window and the refusal of an identification byte inside it reachable within a few thousand clocks. It uses `PERSIST_MASK` = 16'h00F0, so locations 4 to 7 are persistent and the wrap from 0Fh to 00h can be read without starting a commit. The straps are tied to 3'b101. A bus quarter-period of six system clocks leaves room for the two-stage synchroniser, so the slave's SDA changes land inside the low phase of SCL.

// File: rtl/i2cr_pkg.sv
package i2cr_pkg;

    localparam int BYTE_W = 8;
    localparam logic [3:0] ID_PATTERN = 4'b1010;

    typedef enum logic [3:0] {
        S_IDLE,
        S_ID_RX,
        S_ID_ACK,
        S_ADDR_RX,
        S_ADDR_ACK,
        S_DATA_RX,
        S_DATA_ACK,
        S_TX,
        S_TX_ACK
    } slv_state_t;

endpackage

// File: rtl/i2cr_line_sync.sv
module i2cr_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_o,
    output logic start_o,
    output logic stop_o,
    output logic rise_o,
    output logic fall_o
);

    logic [STAGES-1:0] scl_pipe;
    logic [STAGES-1:0] sda_pipe;
    logic              scl_q;
    logic              sda_q;
    logic              scl_s;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_q    <= 1'b1;
            sda_q    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
            sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
            scl_q    <= scl_pipe[STAGES-1];
            sda_q    <= sda_pipe[STAGES-1];
        end
    end

    assign scl_s   = scl_pipe[STAGES-1];
    assign sda_o   = sda_pipe[STAGES-1];
    assign start_o = scl_s & scl_q & sda_q & ~sda_o;
    assign stop_o  = scl_s & scl_q & ~sda_q & sda_o;
    assign rise_o  = scl_s & ~scl_q;
    assign fall_o  = ~scl_s & scl_q;

endmodule

// File: rtl/i2cr_busy_timer.sv
module i2cr_busy_timer #(
    parameter int CYCLES = 2_000_000
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic go_i,
    output logic busy_o
);

    localparam int CW = $clog2(CYCLES + 1);

    logic [CW-1:0] remain;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            remain <= '0;
        end else if (go_i) begin
            remain <= CW'(CYCLES);
        end else if (remain != '0) begin
            remain <= remain - 1'b1;
        end
    end

    assign busy_o = (remain != '0);

endmodule

// File: rtl/i2cr_slave.sv
module i2cr_slave
    import i2cr_pkg::*;
#(
    parameter int                 ADDR_W       = 4,
    parameter int                 SYNC_STAGES  = 2,
    parameter int                 BUSY_CYCLES  = 2_000_000,
    parameter logic [(1<<ADDR_W)-1:0] PERSIST_MASK = 16'h000F
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe_o,
    input  logic [2:0]        strap_i,
    output logic              wr_en_o,
    output logic [ADDR_W-1:0] wr_addr_o,
    output logic [BYTE_W-1:0] wr_data_o,
    output logic [ADDR_W-1:0] rd_addr_o,
    input  logic [BYTE_W-1:0] rd_data_i,
    output logic              busy_o
);

    localparam int CNT_W = $clog2(BYTE_W + 1);

    slv_state_t        state, state_nx;
    logic              sda_s, start_det, stop_det, scl_rise, scl_fall;
    logic [CNT_W-1:0]  bit_cnt;
    logic [BYTE_W-1:0] rx_sh;
    logic [BYTE_W-1:0] tx_sh;
    logic [ADDR_W-1:0] ptr;
    logic              dir_rd;
    logic              mst_ack;
    logic              commit_pend;
    logic              commit_go;
    logic              byte_end;
    logic              id_ok;
    logic              tx_last;

    i2cr_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .scl_i   (scl_i),
        .sda_i   (sda_i),
        .sda_o   (sda_s),
        .start_o (start_det),
        .stop_o  (stop_det),
        .rise_o  (scl_rise),
        .fall_o  (scl_fall)
    );

    i2cr_busy_timer #(.CYCLES(BUSY_CYCLES)) u_timer (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .go_i   (commit_go),
        .busy_o (busy_o)
    );

    assign byte_end  = scl_fall && (bit_cnt == CNT_W'(BYTE_W));
    assign tx_last   = scl_fall && (bit_cnt == CNT_W'(BYTE_W - 1));
    assign id_ok     = (rx_sh[7:4] == ID_PATTERN) && (rx_sh[3:1] == strap_i) && !busy_o;
    assign commit_go = stop_det && commit_pend;

    // next-state decode
    always_comb begin
        state_nx = state;
        if (start_det) begin
            state_nx = S_ID_RX;
        end else if (stop_det) begin
            state_nx = S_IDLE;
        end else begin
            unique case (state)
                S_IDLE:     state_nx = S_IDLE;
                S_ID_RX:    if (byte_end) state_nx = id_ok ? S_ID_ACK : S_IDLE;
                S_ID_ACK:   if (scl_fall) state_nx = dir_rd ? S_TX : S_ADDR_RX;
                S_ADDR_RX:  if (byte_end) state_nx = S_ADDR_ACK;
                S_ADDR_ACK: if (scl_fall) state_nx = S_DATA_RX;
                S_DATA_RX:  if (byte_end) state_nx = S_DATA_ACK;
                S_DATA_ACK: if (scl_fall) state_nx = S_IDLE;
                S_TX:       if (tx_last)  state_nx = S_TX_ACK;
                S_TX_ACK:   if (scl_fall) state_nx = mst_ack ? S_TX : S_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state <= S_IDLE;
        else         state <= state_nx;
    end

    // outputs
    always_comb begin
        sda_oe_o  = 1'b0;
        rd_addr_o = ptr;
        unique case (state)
            S_ID_ACK, S_ADDR_ACK, S_DATA_ACK: sda_oe_o = 1'b1;
            S_TX:                             sda_oe_o = ~tx_sh[BYTE_W-1];
            default:                          sda_oe_o = 1'b0;
        endcase
    end

    // datapath
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            bit_cnt     <= '0;
            rx_sh       <= '0;
            tx_sh       <= '1;
            ptr         <= '0;
            dir_rd      <= 1'b0;
            mst_ack     <= 1'b0;
            commit_pend <= 1'b0;
            wr_en_o     <= 1'b0;
            wr_addr_o   <= '0;
            wr_data_o   <= '0;
        end else begin
            wr_en_o <= 1'b0;
            if (commit_go) commit_pend <= 1'b0;
            if (start_det || stop_det) begin
                bit_cnt <= '0;
            end else begin
                unique case (state)
                    S_ID_RX, S_ADDR_RX, S_DATA_RX: begin
                        if (scl_rise && bit_cnt != CNT_W'(BYTE_W)) begin
                            rx_sh   <= {rx_sh[BYTE_W-2:0], sda_s};
                            bit_cnt <= bit_cnt + 1'b1;
                        end
                        if (byte_end) begin
                            if (state == S_ID_RX) dir_rd <= rx_sh[0];
                            if (state == S_ADDR_RX) ptr <= rx_sh[ADDR_W-1:0];
                            if (state == S_DATA_RX) begin
                                wr_en_o   <= 1'b1;
                                wr_addr_o <= ptr;
                                wr_data_o <= rx_sh;
                                if (PERSIST_MASK[ptr]) commit_pend <= 1'b1;
                            end
                        end
                    end
                    S_ID_ACK, S_ADDR_ACK, S_DATA_ACK: begin
                        if (scl_fall) begin
                            bit_cnt <= '0;
                            if (state == S_ID_ACK && dir_rd) tx_sh <= rd_data_i;
                        end
                    end
                    S_TX: begin
                        if (tx_last) begin
                            bit_cnt <= '0;
                            ptr     <= ptr + 1'b1;
                        end else if (scl_fall) begin
                            tx_sh   <= {tx_sh[BYTE_W-2:0], 1'b1};
                            bit_cnt <= bit_cnt + 1'b1;
                        end
                    end
                    S_TX_ACK: begin
                        if (scl_rise) mst_ack <= ~sda_s;
                        if (scl_fall && mst_ack) tx_sh <= rd_data_i;
                    end
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/i2cr_slave_chk.sv
module i2cr_slave_chk
    import i2cr_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              scl_i,
    input logic              sda_oe_o,
    input logic              wr_en_o,
    input logic              busy_o,
    input logic              stop_det,
    input slv_state_t        state,
    input logic [ADDR_W-1:0] ptr
);

    p_wr_pulse_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_en_o |=> !wr_en_o);

    p_stop_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        stop_det |=> (state == S_IDLE));

    p_ptr_wrap_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state == S_TX_ACK && $past(state) == S_TX) |-> (ptr == ADDR_W'($past(ptr) + 1'b1)));

    p_sda_scl_low_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (scl_i && $past(scl_i) && $past(scl_i, 2) && $past(scl_i, 3)) |-> !$rose(sda_oe_o));

    p_busy_after_stop_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(busy_o) |-> $past(stop_det));

    p_no_ack_busy_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state == S_ID_ACK) |-> !busy_o);

endmodule

bind i2cr_slave i2cr_slave_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .scl_i    (scl_i),
    .sda_oe_o (sda_oe_o),
    .wr_en_o  (wr_en_o),
    .busy_o   (busy_o),
    .stop_det (stop_det),
    .state    (state),
    .ptr      (ptr)
);

// File: tb/i2cr_slave_tb.sv
`timescale 1ns/1ps
module i2cr_slave_tb;

    localparam int         AW    = 4;
    localparam int         BUSY  = 400;
    localparam logic [15:0] PMASK = 16'h00F0;
    localparam logic [2:0] STRAP = 3'b101;
    localparam int         QT    = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       sda_oe, wr_en, busy;
    logic [AW-1:0] wr_addr, rd_addr;
    logic [7:0] wr_data, rd_data;
    logic       sda_line;

    logic [7:0] regs    [16];
    logic [7:0] exp_mem [16];
    logic [7:0] rbuf    [8];
    int         checks = 0, errors = 0, wr_count = 0, busy_cnt = 0;

    always #2 clk = ~clk;

    assign sda_line = sda_m & ~sda_oe;
    assign rd_data  = regs[rd_addr];

    i2cr_slave #(.ADDR_W(AW), .SYNC_STAGES(2), .BUSY_CYCLES(BUSY), .PERSIST_MASK(PMASK)) u_dut (
        .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe_o(sda_oe),
        .strap_i(STRAP), .wr_en_o(wr_en), .wr_addr_o(wr_addr), .wr_data_o(wr_data),
        .rd_addr_o(rd_addr), .rd_data_i(rd_data), .busy_o(busy)
    );

    always @(posedge clk) begin
        if (wr_en) begin
            regs[wr_addr] <= wr_data;
            wr_count <= wr_count + 1;
        end
        if (busy) busy_cnt <= busy_cnt + 1;
    end

    function automatic logic [7:0] id_byte(input logic [3:0] pat, input logic [2:0] st, input logic rw);
        return {pat, st, rw};
    endfunction

    function automatic bit persistent(input logic [7:0] a);
        return PMASK[a[3:0]];
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic q();
        repeat (QT) @(posedge clk);
        #1;
    endtask

    task automatic bus_start();
        sda_m = 1'b1; q(); scl_m = 1'b1; q(); sda_m = 1'b0; q(); scl_m = 1'b0; q();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; q(); scl_m = 1'b1; q(); sda_m = 1'b1; q(); q();
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; q(); scl_m = 1'b1; q(); q(); scl_m = 1'b0; q();
        end
        sda_m = 1'b1; q(); scl_m = 1'b1; q(); ack = ~sda_line; q(); scl_m = 1'b0; q();
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            sda_m = 1'b1; q(); scl_m = 1'b1; q(); b[i] = sda_line; q(); scl_m = 1'b0; q();
        end
        sda_m = ~give_ack; q(); scl_m = 1'b1; q();
        chk("R9 slave releases SDA in master ack bit", sda_oe, 0);
        q(); scl_m = 1'b0; q(); sda_m = 1'b1;
    endtask

    task automatic do_write(input logic [7:0] id, input logic [7:0] addr, input logic [7:0] data,
                            output logic a1, output logic a2, output logic a3);
        a2 = 1'b0; a3 = 1'b0;
        bus_start();
        send_byte(id, a1);
        if (a1) begin
            send_byte(addr, a2);
            send_byte(data, a3);
            if (a3 && persistent(addr)) chk("R10 busy stays low before STOP", busy, 0);
        end
        bus_stop();
        if (a1 && a3) exp_mem[addr[3:0]] = data;
    endtask

    task automatic do_read(input logic [7:0] addr, input int n, output logic ok);
        logic a1, a2, a3;
        bus_start();
        send_byte(id_byte(4'b1010, STRAP, 1'b0), a1);
        send_byte(addr, a2);
        bus_start();
        send_byte(id_byte(4'b1010, STRAP, 1'b1), a3);
        ok = a1 & a2 & a3;
        for (int k = 0; k < n; k++) recv_byte(k != n - 1, rbuf[k]);
        bus_stop();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic a1, a2, a3, ok;
        logic [7:0] b;
        int wc;
        void'($urandom(32'd20240611));
        for (int i = 0; i < 16; i++) begin
            regs[i] = 8'h30 + 8'(i);
            exp_mem[i] = 8'h30 + 8'(i);
        end
        repeat (5) @(posedge clk); #1;
        chk("R12 sda released in reset", sda_oe, 0);
        rst_n = 1'b1;
        repeat (5) @(posedge clk); #1;
        chk("R12 sda released after reset", sda_oe, 0);
        chk("R12 busy low after reset", busy, 0);
        chk("R12 no write strobe after reset", wr_en, 0);

        // R1 R3: basic write
        wc = wr_count;
        do_write(id_byte(4'b1010, STRAP, 1'b0), 8'h02, 8'h5A, a1, a2, a3);
        chk("R1 matching id acked", a1, 1);
        chk("R3 address acked", a2, 1);
        chk("R3 data acked", a3, 1);
        chk("R3 one write strobe", wr_count - wc, 1);
        chk("R10 volatile write leaves busy low", busy, 0);
        do_read(8'h02, 1, ok);
        chk("R6 read header acked", ok, 1);
        chk("R3 R6 read back loc 2", rbuf[0], 8'h5A);

        // R4: upper address bits ignored
        do_write(id_byte(4'b1010, STRAP, 1'b0), 8'h3B, 8'hC3, a1, a2, a3);
        do_read(8'h0B, 1, ok);
        chk("R4 upper address bits ignored", rbuf[0], 8'hC3);

        // R1: mismatched straps and pattern
        wc = wr_count;
        do_write(id_byte(4'b1010, 3'b100, 1'b0), 8'h01, 8'hEE, a1, a2, a3);
        chk("R1 wrong strap not acked", a1, 0);
        do_write(id_byte(4'b1011, STRAP, 1'b0), 8'h01, 8'hEE, a1, a2, a3);
        chk("R1 wrong pattern not acked", a1, 0);
        chk("R1 no write after mismatch", wr_count - wc, 0);
        do_read(8'h01, 1, ok);
        chk("R1 loc 1 untouched", rbuf[0], exp_mem[1]);

        // R7 R6: wrap from 0F to 00
        do_write(id_byte(4'b1010, STRAP, 1'b0), 8'h0E, 8'hA1, a1, a2, a3);
        do_write(id_byte(4'b1010, STRAP, 1'b0), 8'h0F, 8'hB2, a1, a2, a3);
        do_write(id_byte(4'b1010, STRAP, 1'b0), 8'h00, 8'hC4, a1, a2, a3);
        do_read(8'h0E, 4, ok);
        chk("R6 stream byte 0 (loc E)", rbuf[0], 8'hA1);
        chk("R6 stream byte 1 (loc F)", rbuf[1], 8'hB2);
        chk("R7 wrap to loc 0", rbuf[2], 8'hC4);
        chk("R7 continues at loc 1", rbuf[3], exp_mem[1]);

        // R5: second data byte refused
        wc = wr_count;
        bus_start();
        send_byte(id_byte(4'b1010, STRAP, 1'b0), a1);
        send_byte(8'h03, a2);
        send_byte(8'h66, a3);
        send_byte(8'h99, a3);
        chk("R5 extra data byte not acked", a3, 0);
        bus_stop();
        exp_mem[3] = 8'h66;
        chk("R5 only one write strobe", wr_count - wc, 1);
        do_read(8'h03, 2, ok);
        chk("R5 loc 3 holds first byte", rbuf[0], 8'h66);
        chk("R5 loc 4 untouched", rbuf[1], exp_mem[4]);

        // R8: after master NACK the slave stays silent
        bus_start();
        send_byte(id_byte(4'b1010, STRAP, 1'b0), a1);
        send_byte(8'h0E, a2);
        bus_start();
        send_byte(id_byte(4'b1010, STRAP, 1'b1), a3);
        recv_byte(1'b0, b);
        chk("R8 last byte before nack", b, 8'hA1);
        recv_byte(1'b0, b);
        chk("R8 slave silent after nack", b, 8'hFF);
        bus_stop();

        // R2: repeated START abandons a write
        wc = wr_count;
        bus_start();
        send_byte(id_byte(4'b1010, STRAP, 1'b0), a1);
        send_byte(8'h0A, a2);
        bus_start();
        send_byte(id_byte(4'b1010, STRAP, 1'b0), a1);
        chk("R2 id after repeated start acked", a1, 1);
        send_byte(8'h0C, a2);
        send_byte(8'h11, a3);
        bus_stop();
        exp_mem[12] = 8'h11;
        chk("R2 one write after restart", wr_count - wc, 1);
        do_read(8'h0A, 3, ok);
        chk("R2 abandoned loc A untouched", rbuf[0], exp_mem[10]);
        chk("R2 loc C written", rbuf[2], 8'h11);

        // R10 R11: persistent commit
        busy_cnt = 0;
        do_write(id_byte(4'b1010, STRAP, 1'b0), 8'h05, 8'h77, a1, a2, a3);
        chk("R10 busy after STOP", busy, 1);
        do_write(id_byte(4'b1010, STRAP, 1'b0), 8'h06, 8'h12, a1, a2, a3);
        chk("R11 id refused while busy", a1, 0);
        for (int w = 0; w < 5000 && busy; w++) @(posedge clk);
        repeat (2) @(posedge clk); #1;
        chk("R10 busy length", busy_cnt, BUSY);
        do_read(8'h05, 2, ok);
        chk("R11 acked again after busy", ok, 1);
        chk("R10 persistent loc 5 written", rbuf[0], 8'h77);
        chk("R11 refused write not stored", rbuf[1], exp_mem[6]);

        // random volatile traffic
        for (int it = 0; it < 20; it++) begin
            logic [7:0] ad, dt, st;
            int n;
            ad = 8'($urandom_range(0, 255));
            if (persistent(ad)) ad[3] = 1'b1;
            dt = 8'($urandom_range(0, 255));
            do_write(id_byte(4'b1010, STRAP, 1'b0), ad, dt, a1, a2, a3);
            chk("R3 random write acked", a3, 1);
            st = 8'($urandom_range(0, 15));
            n = $urandom_range(1, 4);
            do_read(st, n, ok);
            for (int k = 0; k < n; k++)
                chk("R6 R7 random stream", rbuf[k], exp_mem[4'(st[3:0] + 4'(k))]);
        end
        chk("R10 no busy from volatile traffic", busy, 0);

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule